// File: doc/BRIEF.md
# Single-Cycle 16-Bit Load/Store Processor Core

This block is a small processor that fetches, decodes and completes one 16-bit instruction in every clock cycle. Each instruction word holds a 4-bit operation code in bits [15:12], a first source register in bits [11:8], a second source register in bits [7:4] and a destination register or small constant in bits [3:0]. Sixteen general registers of 16 bits are held inside the core; register 0 is hard-wired to zero. The instruction set covers word load and store, add, subtract, bitwise AND and OR, signed set-less-than, branch-if-equal and an absolute jump.

The core has no memories of its own. It presents the program counter as an instruction address and expects the instruction word back in the same cycle. Data memory is reached through an address, a write-data bus, a read-data bus and two active-low strobes (read and write). The program counter counts bytes, so straight-line code advances it by 2, while branch offsets and jump targets in the instruction are counted in words and scaled by two. A set of debug outputs shows the program counter, the instruction being executed, both register read ports and the ALU result for the current cycle.

Top module: `mini16_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 and every register becomes 0.
- R2: Operation codes 2 (ADD), 3 (SUB), 4 (AND) and 5 (OR) compute first-source op second-source with 16-bit wrap-around, show the result on `dbg_alu` in the same cycle and write it into the register named by bits [3:0] at the clock edge.
- R3: Operation code 6 (SLT) writes 1 into the bits [3:0] register when the first source is less than the second as signed 16-bit numbers, and 0 otherwise.
- R4: Operation code 0 (LW) drives `dmem_addr` with first source plus the zero-extended bits [3:0], drives `dmem_rd_n` low and `dmem_wr_n` high, and writes `dmem_rdata` into the register named by bits [7:4].
- R5: Operation code 1 (SW) drives the same address as LW, drives `dmem_wdata` with the bits [7:4] register, drives `dmem_wr_n` low and `dmem_rd_n` high, and writes no register.
- R6: For every operation code other than 0 and 1 both memory strobes stay high; the two strobes are never low together.
- R7: Register 0 always reads as zero; a write aimed at register 0 has no effect.
- R8: After any instruction that is not a taken branch or a jump, the program counter increases by 2.
- R9: Operation code 7 (BEQ) compares the two source registers; if equal the next program counter is PC + 2 + 2 × (bits [3:0] sign-extended), otherwise PC + 2. It writes no register.
- R10: Operation code 8 (JMP) sets the program counter to bits [11:0] shifted left by one, zero-extended, and writes no register.
- R11: Operation codes 9 to 15 write no register, leave both strobes high and advance the program counter by 2.
- R12: `dbg_pc` equals `imem_addr`, `dbg_instr` equals `imem_rdata`, and `dbg_rd1`/`dbg_rd2` show the registers named by bits [11:8] and [7:4] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Byte address of the instruction to execute |
| imem_rdata | input | 16 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 16 | Data memory address (ALU result) |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Load data returned for `dmem_addr` in the same cycle |
| dmem_rd_n | output | 1 | Data read strobe, active low |
| dmem_wr_n | output | 1 | Data write strobe, active low |
| dbg_pc | output | 16 | Current program counter |
| dbg_instr | output | 16 | Current instruction word |
| dbg_rd1 | output | 16 | Value of the first source register |
| dbg_rd2 | output | 16 | Value of the second source register |
| dbg_alu | output | 16 | ALU result of the current instruction |

## Verification
The ALU result, the memory address, write data, strobes and both debug read ports are combinational from the instruction, so they are due in the same cycle the instruction is presented; the bench places each instruction at the falling edge, waits one time step and samples them before the next rising edge. Register writes, stores and the new program counter take effect at that one rising edge, so the bench reads them back at the following falling edge, registers through a later instruction's first read port. Branch and jump targets are checked on `dbg_pc` one edge after the control instruction, and register values that a control or store instruction must leave alone are read back immediately afterwards.

// File: rtl/mini16_pkg.sv
// Shared widths, operation codes, ALU selections and the decoded control
// record for the single-cycle 16-bit core. Assumes a 4-bit opcode field.
package mini16_pkg;

    localparam int XLEN   = 16;
    localparam int REG_N  = 16;
    localparam int RIDX_W = $clog2(REG_N);
    localparam int OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_LW  = 4'd0,
        OPC_SW  = 4'd1,
        OPC_ADD = 4'd2,
        OPC_SUB = 4'd3,
        OPC_AND = 4'd4,
        OPC_OR  = 4'd5,
        OPC_SLT = 4'd6,
        OPC_BEQ = 4'd7,
        OPC_JMP = 4'd8
    } opc_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'd0,
        ALU_OR  = 3'd1,
        ALU_ADD = 3'd2,
        ALU_SUB = 3'd6,
        ALU_SLT = 3'd7
    } alu_sel_e;

    typedef struct packed {
        logic     reg_we;     // write a register at the edge
        logic     dst_is_rd;  // destination from bits [3:0], else [7:4]
        logic     use_imm;    // ALU second operand is the small constant
        logic     mem_rd_n;   // active-low read strobe
        logic     mem_wr_n;   // active-low write strobe
        logic     load_wb;    // write-back takes memory data
        logic     is_beq;
        logic     is_jmp;
        alu_sel_e alu_sel;
    } ctrl_t;

endpackage

// File: rtl/mini16_decode.sv
// Main control decoder with the opcode-to-ALU translation folded in.
// Assumes unlisted opcodes behave as a no-op that advances the PC.
module mini16_decode
    import mini16_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    // Purpose: map each operation code to its control record.
    always_comb begin
        ctrl.reg_we    = 1'b0;
        ctrl.dst_is_rd = 1'b0;
        ctrl.use_imm   = 1'b0;
        ctrl.mem_rd_n  = 1'b1;
        ctrl.mem_wr_n  = 1'b1;
        ctrl.load_wb   = 1'b0;
        ctrl.is_beq    = 1'b0;
        ctrl.is_jmp    = 1'b0;
        ctrl.alu_sel   = ALU_ADD;
        case (opcode)
            OPC_LW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.mem_rd_n = 1'b0;
                ctrl.load_wb  = 1'b1;
            end
            OPC_SW: begin
                ctrl.use_imm  = 1'b1;
                ctrl.mem_wr_n = 1'b0;
            end
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_SLT: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                case (opcode)
                    OPC_SUB: ctrl.alu_sel = ALU_SUB;
                    OPC_AND: ctrl.alu_sel = ALU_AND;
                    OPC_OR:  ctrl.alu_sel = ALU_OR;
                    OPC_SLT: ctrl.alu_sel = ALU_SLT;
                    default: ctrl.alu_sel = ALU_ADD;
                endcase
            end
            OPC_BEQ: begin
                ctrl.is_beq  = 1'b1;
                ctrl.alu_sel = ALU_SUB;
            end
            OPC_JMP: ctrl.is_jmp = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mini16_alu.sv
// Combinational ALU: add, subtract, AND, OR and signed set-less-than,
// with an all-zero flag used for the equality branch.
module mini16_alu
    import mini16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_sel_e     sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    // Purpose: select the arithmetic or logic result.
    always_comb begin
        case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mini16_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is held at zero; synchronous active-low reset clears all entries.
module mini16_regfile
    import mini16_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = REG_N,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [N];

    // Purpose: one storage process per entry, entry 0 pinned to zero.
    for (genvar gi = 0; gi < N; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n || gi == 0)
                regs[gi] <= '0;
            else if (we && waddr == AW'(gi))
                regs[gi] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mini16_core.sv
// Single-cycle core top: fetch address, decode, register read, ALU,
// memory strobes, write-back and next-PC selection in one clock.
// Assumes instruction and data memories answer combinationally.
module mini16_core
    import mini16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] imem_addr,
    input  logic [15:0] imem_rdata,
    output logic [15:0] dmem_addr,
    output logic [15:0] dmem_wdata,
    input  logic [15:0] dmem_rdata,
    output logic        dmem_rd_n,
    output logic        dmem_wr_n,
    output logic [15:0] dbg_pc,
    output logic [15:0] dbg_instr,
    output logic [15:0] dbg_rd1,
    output logic [15:0] dbg_rd2,
    output logic [15:0] dbg_alu
);

    localparam int JFLD_W = XLEN - OPC_W;

    logic [XLEN-1:0]   pc_q, pc_next, pc_step, br_tgt, jmp_tgt, br_off;
    logic [XLEN-1:0]   instr, rs_val, rt_val, imm, alu_b, alu_y, wb_data;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic [OPC_W-1:0]  opcode;
    logic              alu_zero;
    ctrl_t             ctrl;

    assign instr  = imem_rdata;
    assign opcode = instr[XLEN-1 -: OPC_W];
    assign rs_idx = instr[11:8];
    assign rt_idx = instr[7:4];
    assign rd_idx = instr[3:0];

    mini16_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    mini16_regfile #(.W(XLEN), .N(REG_N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl.reg_we),
        .waddr   (wb_idx),
        .wdata   (wb_data),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign imm   = {{(XLEN-RIDX_W){1'b0}}, rd_idx};
    assign alu_b = ctrl.use_imm ? imm : rt_val;

    mini16_alu #(.W(XLEN)) u_alu (
        .sel  (ctrl.alu_sel),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wb_data = ctrl.load_wb ? dmem_rdata : alu_y;

    // Byte-addressed PC; branch offset and jump field count words.
    assign pc_step = pc_q + XLEN'(2);
    assign br_off  = {{(XLEN-RIDX_W-1){rd_idx[RIDX_W-1]}}, rd_idx, 1'b0};
    assign br_tgt  = pc_step + br_off;
    assign jmp_tgt = {{(XLEN-JFLD_W-1){1'b0}}, instr[JFLD_W-1:0], 1'b0};

    // Purpose: choose the next program counter.
    always_comb begin
        if (ctrl.is_jmp)
            pc_next = jmp_tgt;
        else if (ctrl.is_beq && alu_zero)
            pc_next = br_tgt;
        else
            pc_next = pc_step;
    end

    // Purpose: program counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_rd_n  = ctrl.mem_rd_n;
    assign dmem_wr_n  = ctrl.mem_wr_n;
    assign dbg_pc     = pc_q;
    assign dbg_instr  = instr;
    assign dbg_rd1    = rs_val;
    assign dbg_rd2    = rt_val;
    assign dbg_alu    = alu_y;

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.is_jmp && !ctrl.is_beq) |=> pc_q == $past(pc_q) + XLEN'(2)); // R8

    AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.is_beq && rs_val != rt_val) |=> pc_q == $past(pc_q) + XLEN'(2)); // R9

    AST_JMP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_jmp |=> pc_q[JFLD_W:1] == $past(instr[JFLD_W-1:0])); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dmem_rd_n && !dmem_wr_n)); // R6

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == '0) |-> rs_val == '0); // R7

endmodule

// File: tb/mini16_core_tb.sv
module mini16_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd_n, dmem_wr_n;
    logic [15:0] dbg_pc, dbg_instr, dbg_rd1, dbg_rd2, dbg_alu;

    logic [15:0] imem [32];
    logic [15:0] dmem [32];
    logic [15:0] vals [8];
    int          errs   = 0;
    int          checks = 0;
    logic [15:0] exp_pc;

    always #2 clk = ~clk;

    assign imem_rdata = imem[imem_addr[5:1]];
    assign dmem_rdata = dmem[dmem_addr[4:0]];

    always @(posedge clk) begin
        if (!dmem_wr_n) dmem[dmem_addr[4:0]] <= dmem_wdata;
    end

    mini16_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_rd_n(dmem_rd_n), .dmem_wr_n(dmem_wr_n),
        .dbg_pc(dbg_pc), .dbg_instr(dbg_instr), .dbg_rd1(dbg_rd1),
        .dbg_rd2(dbg_rd2), .dbg_alu(dbg_alu)
    );

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] a,
                                        input logic [3:0] b, input logic [3:0] c);
        return {op, a, b, c};
    endfunction

    function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] a,
                                          input logic [15:0] b);
        case (op)
            4'd2:    return a + b;
            4'd3:    return a - b;
            4'd4:    return a & b;
            4'd5:    return a | b;
            default: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Place an instruction at the current PC and let the logic settle.
    task automatic put(input logic [15:0] ins);
        imem[dbg_pc[5:1]] = ins;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] ins);
        put(ins);
        tick();
        exp_pc = exp_pc + 16'd2;
    endtask

    // Read a register through the first read port of an OR into R0.
    task automatic rd_reg(input logic [3:0] idx, output logic [15:0] v);
        put(enc(4'd5, idx, 4'd0, 4'd0));
        v = dbg_rd1;
        tick();
        exp_pc = exp_pc + 16'd2;
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] p;
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                 16'h8000, 16'hFFFF, 16'h1234, 16'hFFFE};
        for (int i = 0; i < 32; i++) begin
            imem[i] = 16'h5000;
            dmem[i] = 16'h0000;
        end
        for (int i = 0; i < 8; i++) dmem[i] = vals[i];
        dmem[8] = 16'd3;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", dbg_pc, 16'h0000);
        rst_n = 1'b1;
        exp_pc = 16'h0000;

        // R1: all registers cleared by reset
        for (int r = 1; r < 16; r++) begin
            rd_reg(4'(r), v);
            chk("R1 register after reset", v, 16'h0000);
        end
        chk("R8 sequential pc", dbg_pc, exp_pc);

        // R2/R3/R4/R12: sweep of operand pairs over every ALU instruction
        for (int ai = 0; ai < 8; ai++) begin
            for (int bi = 0; bi < 8; bi++) begin
                for (int k = 2; k <= 6; k++) begin
                    put(enc(4'd0, 4'd0, 4'd1, 4'(ai)));
                    chk("R4 load strobe rd_n", {15'd0, dmem_rd_n}, 16'd0);
                    chk("R4 load strobe wr_n", {15'd0, dmem_wr_n}, 16'd1);
                    chk("R4 load address", dmem_addr, 16'(ai));
                    tick(); exp_pc = exp_pc + 16'd2;
                    run(enc(4'd0, 4'd0, 4'd2, 4'(bi)));
                    put(enc(4'(k), 4'd1, 4'd2, 4'd3));
                    chk("R12 dbg_instr", dbg_instr, enc(4'(k), 4'd1, 4'd2, 4'd3));
                    chk("R12 dbg_rd1", dbg_rd1, vals[ai]);
                    chk("R12 dbg_rd2", dbg_rd2, vals[bi]);
                    chk("R6 strobes high on ALU op", {14'd0, dmem_rd_n, dmem_wr_n}, 16'd3);
                    chk(k == 6 ? "R3 slt result" : "R2 alu result",
                        dbg_alu, model(4'(k), vals[ai], vals[bi]));
                    tick(); exp_pc = exp_pc + 16'd2;
                    rd_reg(4'd3, v);
                    chk(k == 6 ? "R3 slt writeback" : "R2 writeback",
                        v, model(4'(k), vals[ai], vals[bi]));
                end
            end
        end
        chk("R8 pc after sweep", dbg_pc, exp_pc);
        chk("R12 dbg_pc matches fetch address", dbg_pc, imem_addr);

        // R7: writes aimed at R0 are dropped, including a load
        run(enc(4'd2, 4'd1, 4'd1, 4'd0));
        run(enc(4'd0, 4'd0, 4'd0, 4'd5));
        rd_reg(4'd0, v);
        chk("R7 R0 reads zero", v, 16'h0000);

        // R4: address uses a non-zero base register
        run(enc(4'd0, 4'd0, 4'd4, 4'd8));
        put(enc(4'd0, 4'd4, 4'd5, 4'd4));
        chk("R4 base plus offset", dmem_addr, 16'd7);
        tick(); exp_pc = exp_pc + 16'd2;
        rd_reg(4'd5, v);
        chk("R4 loaded value", v, vals[7]);

        // R5: store strobes, address, data and no register write
        put(enc(4'd1, 4'd4, 4'd5, 4'd9));
        chk("R5 store address", dmem_addr, 16'd12);
        chk("R5 store data", dmem_wdata, vals[7]);
        chk("R5 store strobes", {14'd0, dmem_rd_n, dmem_wr_n}, 16'd2);
        tick(); exp_pc = exp_pc + 16'd2;
        chk("R5 memory written", dmem[12], vals[7]);
        rd_reg(4'd9, v);
        chk("R5 no register write", v, 16'h0000);

        // R9: branch not taken, no write to the offset-named register
        put(enc(4'd7, 4'd0, 4'd5, 4'd3));
        chk("R6 strobes high on branch", {14'd0, dmem_rd_n, dmem_wr_n}, 16'd3);
        tick(); exp_pc = exp_pc + 16'd2;
        chk("R9 not taken pc", dbg_pc, exp_pc);
        rd_reg(4'd3, v);
        chk("R9 no write on not taken", v, 16'h0000);

        // R9: taken forward with offset 5
        p = dbg_pc;
        put(enc(4'd7, 4'd0, 4'd0, 4'd5));
        tick();
        exp_pc = p + 16'd2 + 16'd10;
        chk("R9 taken forward pc", dbg_pc, exp_pc);
        rd_reg(4'd5, v);
        chk("R9 no write on taken", v, vals[7]);

        // R9: taken backward with offset -2
        p = dbg_pc;
        put(enc(4'd7, 4'd0, 4'd0, 4'hE));
        tick();
        exp_pc = p + 16'd2 - 16'd4;
        chk("R9 taken backward pc", dbg_pc, exp_pc);

        // R10: jump targets
        put(16'h8002);
        chk("R6 strobes high on jump", {14'd0, dmem_rd_n, dmem_wr_n}, 16'd3);
        tick();
        exp_pc = 16'h0004;
        chk("R10 jump small field", dbg_pc, exp_pc);
        put(16'h8FFF);
        tick();
        exp_pc = 16'h1FFE;
        chk("R10 jump full field", dbg_pc, exp_pc);
        put(16'h8013);
        tick();
        exp_pc = 16'h0026;
        chk("R10 jump pc", dbg_pc, exp_pc);
        rd_reg(4'd3, v);
        chk("R10 no register write", v, 16'h0000);

        // R11: unused opcodes do nothing but advance the PC
        for (int op = 9; op < 16; op++) begin
            put(enc(4'(op), 4'd5, 4'd0, 4'd4));
            chk("R11 strobes high", {14'd0, dmem_rd_n, dmem_wr_n}, 16'd3);
            tick(); exp_pc = exp_pc + 16'd2;
            chk("R11 pc advance", dbg_pc, exp_pc);
            rd_reg(4'd4, v);
            chk("R11 no register write", v, 16'd3);
        end

        // R1: reset in mid-run returns PC and registers to zero
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        exp_pc = 16'h0000;
        chk("R1 pc after second reset", dbg_pc, 16'h0000);
        rd_reg(4'd5, v);
        chk("R1 register after second reset", v, 16'h0000);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule